// File: doc/BRIEF.md
# Dual-Law Serial Clock Generator

This block derives a serial-interface clock from the module clock for a shift engine that runs in controller mode. A law-select input chooses between two ways of setting the rate. The linear law divides by 2*(n+1) and takes n from an 8-bit ratio field. The power-of-two law divides by 2^(n+1) and takes n from a 4-bit exponent field. Either law can reach the fastest rate, which is the module clock divided by two.

The clock toggles only while the burst-enable input is high. At all other times it sits at the idle polarity input. On the cycle the clock leaves idle, the block raises a one-cycle leading-edge strobe. On the cycle it returns to idle, it raises a one-cycle trailing-edge strobe. The shift engine uses these strobes to launch and capture bits. The rate fields, the law select and the polarity are captured only while no burst runs. Each burst therefore keeps one fixed rate and begins with a complete idle half-period.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `lin_mode` = 1, the clock period is 2*(`lin_div`+1) module-clock cycles.
- R2: With `lin_mode` = 0, the clock period is 2^(`pow_exp`+1) module-clock cycles.
- R3: Setting `lin_div` = 0 in linear mode gives a period of 2 cycles, and so does setting `pow_exp` = 0 in power-of-two mode.
- R4: Out of reset, and one cycle after `burst_en` is sampled low, `sclk` equals `cpol` and both strobes are 0.
- R5: Each clock period carries exactly one `lead_stb` pulse and one `trail_stb` pulse, each one cycle wide. The two never fire together. `lead_stb` coincides with `sclk` moving to the level opposite `cpol`, and `trail_stb` coincides with its return to `cpol`.
- R6: Both laws give a 50 percent duty cycle: `sclk` spends H cycles at the active level and H at idle, where H is half the period.
- R7: Changes to `lin_mode`, `lin_div`, `pow_exp` or `cpol` while `burst_en` is high have no effect until the burst ends. The next burst uses the new values.
- R8: When `burst_en` falls, the half-period count clears. The first `lead_stb` of the next burst appears H cycles after `burst_en` is first sampled high, even if the previous burst was cut off partway through a period.
- R9: The field that the current law does not use has no effect on the rate: `pow_exp` is ignored in linear mode and `lin_div` in power-of-two mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | Clock runs while high |
| cpol | input | 1 | Idle level of `sclk` |
| lin_mode | input | 1 | 1 selects the linear law, 0 selects the power-of-two law |
| lin_div | input | 8 | Linear ratio field n |
| pow_exp | input | 4 | Power-of-two exponent field n |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle pulse when `sclk` leaves idle |
| trail_stb | output | 1 | One-cycle pulse when `sclk` returns to idle |

## Verification
The assertions assume that a burst is only counted as separate when `burst_en` has been sampled low for at least one edge in between. Under that assumption, every rise of `burst_en` is a fresh start from idle. They also assume that `cpol` seen during a low `burst_en` is the level that the next burst idles at, and the shadow capture guarantees this. The stimulus changes every input just after a falling clock edge. It holds `burst_en` low for at least one full cycle before each new burst. It changes the rate and polarity inputs mid-burst only in the test that checks they are held off.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    // Law select encoding on the lin_mode input.
    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_law_e;

    // Counter width needed to hold the largest half-period minus one
    // for either law.
    function automatic int cnt_width(input int lin_w, input int exp_w);
        int pow_w;
        pow_w = 2 ** exp_w;
        return (lin_w + 1 > pow_w) ? lin_w + 1 : pow_w;
    endfunction

endpackage

// File: rtl/spi_clkdiv_cfg.sv
module spi_clkdiv_cfg
    import spi_clkdiv_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_en,
    input  logic             lin_mode,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] pow_exp,
    input  logic             cpol,
    output logic [CNT_W-1:0] limit_q,
    output logic             cpol_hold_q
);

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic             pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [CNT_W-1:0] lin_limit;
    logic [CNT_W-1:0] pow_limit;

    // Half-period minus one for each law.
    always_comb begin
        lin_limit = CNT_W'(lin_div);
        pow_limit = (CNT_W'(1) << pow_exp) - CNT_W'(1);
    end

    always_comb begin
        cfg_d = cfg_q;
        if (!burst_en) begin
            cfg_d.pol   = cpol;
            cfg_d.limit = (div_law_e'(lin_mode) == DIV_LINEAR) ? lin_limit : pow_limit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign limit_q     = cfg_q.limit;
    assign cpol_hold_q = cfg_q.pol;

    // R7: the captured polarity tracks the input only across idle edges
    a_r7_pol_follows_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> (cpol_hold_q == $past(cpol)));

endmodule

// File: rtl/spi_clkdiv_engine.sv
module spi_clkdiv_engine #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_en,
    input  logic             cpol_idle,
    input  logic             cpol_hold,
    input  logic [CNT_W-1:0] limit,
    output logic             sclk_q,
    output logic             lead_q,
    output logic             trail_q
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
        logic             sclk;
        logic             lead;
        logic             trail;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d       = eng_q;
        eng_d.lead  = 1'b0;
        eng_d.trail = 1'b0;
        if (!burst_en) begin
            eng_d.cnt   = '0;
            eng_d.phase = 1'b0;
            eng_d.sclk  = cpol_idle;
        end else if (eng_q.cnt == limit) begin
            eng_d.cnt   = '0;
            eng_d.phase = ~eng_q.phase;
            eng_d.sclk  = cpol_hold ^ ~eng_q.phase;
            eng_d.lead  = ~eng_q.phase;
            eng_d.trail = eng_q.phase;
        end else begin
            eng_d.cnt = eng_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sclk_q  = eng_q.sclk;
    assign lead_q  = eng_q.lead;
    assign trail_q = eng_q.trail;

    // R5: the two strobes are mutually exclusive
    a_r5_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_q && trail_q));

    // R5: during a burst the clock moves exactly when a strobe fires
    a_r5_toggle_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        burst_en |=> ((sclk_q != $past(sclk_q)) == (lead_q || trail_q)));

    // R4: an idle cycle leaves the clock at the polarity input
    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> (sclk_q == $past(cpol_idle)) && !lead_q && !trail_q);

    // R6: the half-period counter stays within the captured limit
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.cnt <= limit);

    // R8: a low burst enable clears the count
    a_r8_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> (eng_q.cnt == '0));

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
    import spi_clkdiv_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_en,
    input  logic             cpol,
    input  logic             lin_mode,
    input  logic [LIN_W-1:0] lin_div,
    input  logic [EXP_W-1:0] pow_exp,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);

    localparam int CNT_W = cnt_width(LIN_W, EXP_W);

    logic [CNT_W-1:0] limit;
    logic             cpol_hold;

    spi_clkdiv_cfg #(
        .LIN_W (LIN_W),
        .EXP_W (EXP_W),
        .CNT_W (CNT_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_en    (burst_en),
        .lin_mode    (lin_mode),
        .lin_div     (lin_div),
        .pow_exp     (pow_exp),
        .cpol        (cpol),
        .limit_q     (limit),
        .cpol_hold_q (cpol_hold)
    );

    spi_clkdiv_engine #(
        .CNT_W (CNT_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_en  (burst_en),
        .cpol_idle (cpol),
        .cpol_hold (cpol_hold),
        .limit     (limit),
        .sclk_q    (sclk),
        .lead_q    (lead_stb),
        .trail_q   (trail_stb)
    );

    // R5: a leading strobe always lands on the active level
    a_r5_lead_active: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sclk != cpol_hold));

    // R5: a trailing strobe always lands on the idle level
    a_r5_trail_idle: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sclk == cpol_hold));

endmodule

// File: tb/tb_spi_sclk_divider.sv
module tb_spi_sclk_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_en = 1'b0;
    logic       cpol = 1'b0;
    logic       lin_mode = 1'b1;
    logic [7:0] lin_div = '0;
    logic [3:0] pow_exp = '0;
    logic       sclk, lead_stb, trail_stb;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    spi_sclk_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .burst_en  (burst_en),
        .cpol      (cpol),
        .lin_mode  (lin_mode),
        .lin_div   (lin_div),
        .pow_exp   (pow_exp),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Runs one burst and checks it against half-period h. The chg flag
    // rewrites the configuration inputs right after the first burst cycle.
    task automatic run_burst(input logic mode, input logic [7:0] lin, input logic [3:0] ex,
                             input logic pol, input int h, input int periods,
                             input string rtag, input logic chg,
                             input logic mode2, input logic [7:0] lin2,
                             input logic [3:0] ex2, input logic pol2);
        int first_lead = -1;
        int leads = 0, trails = 0, sclk_bad = 0, stb_bad = 0;
        int total = periods * 2 * h + h;
        @(negedge clk);
        lin_mode = mode; lin_div = lin; pow_exp = ex; cpol = pol; burst_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4", "idle level before burst", int'(sclk), int'(pol));
        burst_en = 1'b1;
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            if (i == 1 && chg) begin
                lin_mode = mode2; lin_div = lin2; pow_exp = ex2; cpol = pol2;
            end
            if (lead_stb) begin
                leads++;
                if (first_lead < 0) first_lead = i;
            end
            if (trail_stb) trails++;
            if (lead_stb != ((i % (2 * h)) == h)) stb_bad++;
            if (trail_stb != ((i % (2 * h)) == 0)) stb_bad++;
            if (sclk != (((i % (2 * h)) >= h) ? ~pol : pol)) sclk_bad++;
        end
        burst_en = 1'b0;
        @(negedge clk);
        chk("R4", "idle level after burst", int'(sclk), int'(cpol));
        chk("R8", "first leading strobe cycle", first_lead, h);
        chk(rtag, "clock waveform mismatches", sclk_bad, 0);
        chk("R6", "leading strobe count", leads, periods + 1);
        chk("R6", "trailing strobe count", trails, periods);
        chk("R5", "strobe placement mismatches", stb_bad, 0);
    endtask

    task automatic t_reset();
        chk("R4", "reset sclk", int'(sclk), 0);
        chk("R4", "reset lead", int'(lead_stb), 0);
        chk("R4", "reset trail", int'(trail_stb), 0);
    endtask

    task automatic t_linear();
        run_burst(1'b1, 8'd2, 4'd0, 1'b0, 3, 3, "R1", 1'b0, 1'b0, '0, '0, 1'b0);
        run_burst(1'b1, 8'd5, 4'd0, 1'b1, 6, 2, "R1", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_pow2();
        run_burst(1'b0, 8'd0, 4'd2, 1'b0, 4, 3, "R2", 1'b0, 1'b0, '0, '0, 1'b0);
        run_burst(1'b0, 8'd0, 4'd3, 1'b1, 8, 2, "R2", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_fastest();
        run_burst(1'b1, 8'd0, 4'd9, 1'b0, 1, 5, "R3", 1'b0, 1'b0, '0, '0, 1'b0);
        run_burst(1'b0, 8'd77, 4'd0, 1'b1, 1, 5, "R3", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_unused_field();
        // R9: exponent ignored in linear mode, ratio ignored in power-of-two mode
        run_burst(1'b1, 8'd3, 4'd7, 1'b0, 4, 2, "R9", 1'b0, 1'b0, '0, '0, 1'b0);
        run_burst(1'b0, 8'd200, 4'd1, 1'b0, 2, 3, "R9", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_hold();
        // R7: mid-burst change to power-of-two n=3, polarity 1 must not apply
        run_burst(1'b1, 8'd1, 4'd0, 1'b0, 2, 3, "R7", 1'b1, 1'b0, 8'd9, 4'd3, 1'b1);
        // R7: the next burst picks up the new settings
        run_burst(1'b0, 8'd9, 4'd3, 1'b1, 8, 2, "R7", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_restart();
        // R8: cut a burst partway through its active half, then restart
        @(negedge clk);
        lin_mode = 1'b1; lin_div = 8'd4; cpol = 1'b0; burst_en = 1'b1;
        repeat (7) @(negedge clk);
        burst_en = 1'b0;
        @(negedge clk);
        chk("R8", "clock idle after abort", int'(sclk), 0);
        run_burst(1'b1, 8'd4, 4'd0, 1'b0, 5, 2, "R8", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_linear();
        t_pow2();
        t_fastest();
        t_unused_field();
        t_hold();
        t_restart();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_run();
    end

endmodule